// File: doc/BRIEF.md
# Per-Pixel Multimodal Background Classifier

This block decides, for one 8-bit grey pixel at a time, whether the pixel belongs to a moving object or to the static background. It also returns the updated background model for that pixel. The model for each pixel has three modes. Each mode holds an integer mean and an unsigned fixed-point weight, and the modes arrive ordered by decreasing weight. The model also holds the value the pixel took the last time it was processed. A caller fetches the model from its own storage and presents it with the pixel on a one-cycle valid strobe. Two cycles later it writes back the returned model on the output strobe.

The pixel is tested against each mode in turn, highest weight first. A mode claims the pixel when the pixel lies within a programmable ratio of that mode's mean. For the claiming mode, the pixel is compared with the stored processed value, using half of that same ratio window as the threshold. This temporal test decides between foreground and background. A background hit reinforces the mode's weight and moves its mean one grey level toward the pixel. A foreground hit only decays the weight. When no mode claims the pixel, the lowest mode is overwritten with the pixel value and a small weight. Re-sorting the modes is left to the caller.

Top module: `fgbg_classifier`

## Requirements
- R1: A synchronous active-high reset drives valid_o low and every output mean, weight, processed value and foreground code to 0.
- R2: Each one-cycle valid_i pulse produces exactly one valid_o pulse, two clock edges later.
- R3: With span = floor(mean·ratio_i/256), mode k matches when |pix − mean_k| ≤ span_k. Modes are tried in index order 0, 1, 2 (mode 0 carries the highest weight), and only the lowest-index matching mode is used.
- R4: If the matching mode has |pix − prev_i| > floor(span/2), the pixel is foreground. That mode's weight becomes w − (w >> ALPHA_SHIFT) and its mean stays unchanged.
- R5: If the matching mode does not meet the R4 condition, the pixel is background. The weight becomes w − (w >> ALPHA_SHIFT) + 2^(16−ALPHA_SHIFT), saturated at 65535. The mean moves by +1 when pix is above it, by −1 when pix is below it, and stays the same when they are equal.
- R6: On any match, proc_o equals the current pixel.
- R7: When no mode matches, the pixel is foreground. Mode 2's mean becomes pix, its weight becomes W_LOW, and proc_o takes the incoming mean of mode 0.
- R8: Every mode other than the one updated under R4, R5 or R7 leaves with its incoming mean and weight.
- R9: fg_o is 255 for foreground and 0 for background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Presents a pixel and its model for one cycle |
| pix_i | input | 8 | Current grey level |
| ratio_i | input | 8 | Match ratio, in units of 1/256 |
| prev_i | input | 8 | Stored processed value from the previous frame |
| mean_i | input | 3x8 | Mode means, index 0 has the highest weight |
| weight_i | input | 3x16 | Mode weights, unsigned fractions |
| valid_o | output | 1 | Updated model and class are valid |
| mean_o | output | 3x8 | Updated mode means |
| weight_o | output | 3x16 | Updated mode weights |
| proc_o | output | 8 | New processed value |
| fg_o | output | 8 | 255 for foreground, 0 for background |

## Verification
The classifier is driven with pixels chosen to hit each mode on its own, to miss every mode, and to land exactly on the window edge and one level past it. These cases separate the three update kinds from one another and detect an off-by-one error in the window compare. Other pixels overlap two mode windows, which shows whether the priority order is honoured. A threshold-edge pair sets the temporal difference equal to half the span and then one level above it, which pins down the strict comparison. A larger ratio value turns a former miss into a hit, and a full-scale weight checks the saturation.

// File: rtl/fgbg_pkg.sv
package fgbg_pkg;

  // How one mode is rewritten in the second stage
  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_BG   = 2'd1,
    UPD_FG   = 2'd2,
    UPD_NEW  = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/fgbg_mode_check.sv
// Ratio-window test and temporal-difference test for one mode.
module fgbg_mode_check #(
  parameter int PIX_W      = 8,
  parameter int RATIO_W    = 8,
  parameter int RATIO_FRAC = 8
) (
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [PIX_W-1:0]   prev_i,
  input  logic [PIX_W-1:0]   mean_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               hit_o,
  output logic               moved_o
);
  localparam int PW = PIX_W + RATIO_W;

  logic [PW-1:0]    prod;
  logic [PW-1:0]    span;
  logic [PW-1:0]    thr;
  logic [PIX_W-1:0] d_mean;
  logic [PIX_W-1:0] d_prev;

  assign prod   = {{RATIO_W{1'b0}}, mean_i} * {{PIX_W{1'b0}}, ratio_i};
  assign span   = prod >> RATIO_FRAC;
  assign thr    = span >> 1;
  assign d_mean = (pix_i >= mean_i) ? (pix_i - mean_i) : (mean_i - pix_i);
  assign d_prev = (pix_i >= prev_i) ? (pix_i - prev_i) : (prev_i - pix_i);
  assign hit_o   = ({{RATIO_W{1'b0}}, d_mean} <= span);
  assign moved_o = ({{RATIO_W{1'b0}}, d_prev} > thr);

endmodule

// File: rtl/fgbg_mode_update.sv
// Computes the next mean and weight of one mode for a given update kind.
module fgbg_mode_update
  import fgbg_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int W_W         = 16,
  parameter int ALPHA_SHIFT = 4,
  parameter int W_LOW       = 256
) (
  input  upd_kind_e        kind_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] mean_i,
  input  logic [W_W-1:0]   weight_i,
  output logic [PIX_W-1:0] mean_o,
  output logic [W_W-1:0]   weight_o
);
  localparam logic [W_W:0]   ALPHA = (W_W+1)'(1) << (W_W - ALPHA_SHIFT);
  localparam logic [W_W-1:0] LOWW  = W_W'(W_LOW);

  logic [W_W-1:0]   decay;
  logic [W_W:0]     boost;
  logic [W_W-1:0]   boost_sat;
  logic [PIX_W-1:0] stepped;

  assign decay     = weight_i - (weight_i >> ALPHA_SHIFT);
  assign boost     = {1'b0, decay} + ALPHA;
  assign boost_sat = boost[W_W] ? {W_W{1'b1}} : boost[W_W-1:0];

  always_comb begin
    if (pix_i > mean_i)      stepped = mean_i + PIX_W'(1);
    else if (pix_i < mean_i) stepped = mean_i - PIX_W'(1);
    else                     stepped = mean_i;
  end

  always_comb begin
    unique case (kind_i)
      UPD_BG:  begin mean_o = stepped; weight_o = boost_sat; end
      UPD_FG:  begin mean_o = mean_i;  weight_o = decay;     end
      UPD_NEW: begin mean_o = pix_i;   weight_o = LOWW;      end
      default: begin mean_o = mean_i;  weight_o = weight_i;  end
    endcase
  end

endmodule

// File: rtl/fgbg_classifier.sv
// Two-stage per-pixel classifier: stage 1 tests all modes, stage 2 updates.
module fgbg_classifier
  import fgbg_pkg::*;
#(
  parameter int MODES       = 3,
  parameter int PIX_W       = 8,
  parameter int W_W         = 16,
  parameter int RATIO_W     = 8,
  parameter int RATIO_FRAC  = 8,
  parameter int ALPHA_SHIFT = 4,
  parameter int W_LOW       = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_i,
  input  logic [PIX_W-1:0]            pix_i,
  input  logic [RATIO_W-1:0]          ratio_i,
  input  logic [PIX_W-1:0]            prev_i,
  input  logic [MODES-1:0][PIX_W-1:0] mean_i,
  input  logic [MODES-1:0][W_W-1:0]   weight_i,
  output logic                        valid_o,
  output logic [MODES-1:0][PIX_W-1:0] mean_o,
  output logic [MODES-1:0][W_W-1:0]   weight_o,
  output logic [PIX_W-1:0]            proc_o,
  output logic [PIX_W-1:0]            fg_o
);
  localparam int SEL_W = (MODES > 1) ? $clog2(MODES) : 1;
  localparam logic [PIX_W-1:0] FG_CODE = {PIX_W{1'b1}};

  // ---------------- stage 1: per-mode tests ----------------
  logic [MODES-1:0] hit_c, moved_c;

  for (genvar k = 0; k < MODES; k++) begin : g_check
    fgbg_mode_check #(
      .PIX_W(PIX_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC)
    ) check_i (
      .pix_i  (pix_i),
      .prev_i (prev_i),
      .mean_i (mean_i[k]),
      .ratio_i(ratio_i),
      .hit_o  (hit_c[k]),
      .moved_o(moved_c[k])
    );
  end

  logic                        s1_valid;
  logic [PIX_W-1:0]            s1_pix;
  logic [MODES-1:0][PIX_W-1:0] s1_mean;
  logic [MODES-1:0][W_W-1:0]   s1_weight;
  logic [MODES-1:0]            s1_hit, s1_moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_pix    <= '0;
      s1_mean   <= '0;
      s1_weight <= '0;
      s1_hit    <= '0;
      s1_moved  <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_pix    <= pix_i;
        s1_mean   <= mean_i;
        s1_weight <= weight_i;
        s1_hit    <= hit_c;
        s1_moved  <= moved_c;
      end
    end
  end

  // ---------------- stage 2: select and update ----------------
  logic             any_hit;
  logic [SEL_W-1:0] sel;
  logic             sel_moved;

  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int k = MODES - 1; k >= 0; k--) begin
      if (s1_hit[k]) begin
        any_hit = 1'b1;
        sel     = SEL_W'(k);
      end
    end
  end

  assign sel_moved = s1_moved[sel];

  upd_kind_e                   kind [MODES];
  logic [MODES-1:0][PIX_W-1:0] mean_n;
  logic [MODES-1:0][W_W-1:0]   weight_n;

  for (genvar k = 0; k < MODES; k++) begin : g_upd
    always_comb begin
      if (any_hit)
        kind[k] = (sel == SEL_W'(k)) ? (sel_moved ? UPD_FG : UPD_BG) : UPD_KEEP;
      else
        kind[k] = (k == MODES - 1) ? UPD_NEW : UPD_KEEP;
    end

    fgbg_mode_update #(
      .PIX_W(PIX_W), .W_W(W_W), .ALPHA_SHIFT(ALPHA_SHIFT), .W_LOW(W_LOW)
    ) update_i (
      .kind_i  (kind[k]),
      .pix_i   (s1_pix),
      .mean_i  (s1_mean[k]),
      .weight_i(s1_weight[k]),
      .mean_o  (mean_n[k]),
      .weight_o(weight_n[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      mean_o   <= '0;
      weight_o <= '0;
      proc_o   <= '0;
      fg_o     <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        mean_o   <= mean_n;
        weight_o <= weight_n;
        proc_o   <= any_hit ? s1_pix : s1_mean[0];
        fg_o     <= (!any_hit || sel_moved) ? FG_CODE : '0;
      end
    end
  end

endmodule

// File: rtl/fgbg_classifier_chk.sv
// Property checker, bound to every instance of the classifier.
module fgbg_classifier_chk #(
  parameter int MODES = 3,
  parameter int PIX_W = 8,
  parameter int W_W   = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        valid_i,
  input logic [PIX_W-1:0]            pix_i,
  input logic [MODES-1:0][PIX_W-1:0] mean_i,
  input logic [MODES-1:0][W_W-1:0]   weight_i,
  input logic                        valid_o,
  input logic [MODES-1:0][PIX_W-1:0] mean_o,
  input logic [MODES-1:0][W_W-1:0]   weight_o,
  input logic [PIX_W-1:0]            proc_o,
  input logic [PIX_W-1:0]            fg_o
);
  logic                        past_ok;
  logic                        d1_valid, d2_valid;
  logic [PIX_W-1:0]            d1_pix, d2_pix;
  logic [MODES-1:0][PIX_W-1:0] d1_mean, d2_mean;
  logic [MODES-1:0][W_W-1:0]   d1_weight, d2_weight;
  int                          n_changed;

  always_ff @(posedge clk) begin
    past_ok <= 1'b1;
    if (rst) begin
      d1_valid <= 1'b0; d2_valid <= 1'b0;
      d1_pix <= '0; d2_pix <= '0;
      d1_mean <= '0; d2_mean <= '0;
      d1_weight <= '0; d2_weight <= '0;
    end else begin
      d1_valid <= valid_i;  d2_valid <= d1_valid;
      d1_pix <= pix_i;      d2_pix <= d1_pix;
      d1_mean <= mean_i;    d2_mean <= d1_mean;
      d1_weight <= weight_i; d2_weight <= d1_weight;
    end
  end

  always_comb begin
    n_changed = 0;
    for (int k = 0; k < MODES; k++)
      if (mean_o[k] != d2_mean[k] || weight_o[k] != d2_weight[k])
        n_changed++;
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (!valid_o && proc_o == '0 && fg_o == '0 &&
                                 mean_o == '0 && weight_o == '0));

  a_r2_latency_fwd: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ##1 valid_o);

  a_r2_latency_back: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> d2_valid);

  a_r9_fg_code: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (fg_o == '0 || fg_o == {PIX_W{1'b1}}));

  a_r6_proc_background: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fg_o == '0) |-> proc_o == d2_pix);

  a_r8_single_mode: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> n_changed <= 1);

endmodule

bind fgbg_classifier fgbg_classifier_chk #(
  .MODES(MODES), .PIX_W(PIX_W), .W_W(W_W)
) chk_i (
  .clk(clk), .rst(rst), .valid_i(valid_i), .pix_i(pix_i),
  .mean_i(mean_i), .weight_i(weight_i), .valid_o(valid_o),
  .mean_o(mean_o), .weight_o(weight_o), .proc_o(proc_o), .fg_o(fg_o)
);

// File: tb/fgbg_classifier_tb_top.sv
module fgbg_classifier_tb_top;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                valid_i = 1'b0;
  logic [7:0]          pix_i = '0, ratio_i = '0, prev_i = '0;
  logic [2:0][7:0]     mean_i = '0;
  logic [2:0][15:0]    weight_i = '0;
  logic                valid_o;
  logic [2:0][7:0]     mean_o;
  logic [2:0][15:0]    weight_o;
  logic [7:0]          proc_o, fg_o;

  fgbg_classifier dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pix_i(pix_i),
    .ratio_i(ratio_i), .prev_i(prev_i), .mean_i(mean_i),
    .weight_i(weight_i), .valid_o(valid_o), .mean_o(mean_o),
    .weight_o(weight_o), .proc_o(proc_o), .fg_o(fg_o)
  );

  int n_run = 0;
  int n_fail = 0;

  // {pix, prev, ratio, m0, m1, m2, w0, w1, w2, em0, em1, em2, ew0, ew1, ew2, eproc, efg}
  localparam logic [183:0] VEC [NV] = '{
    {8'd105,8'd103,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd101,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd105,8'd0},
    {8'd95,8'd110,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd200, 16'd37500,16'd20000,16'd8000, 8'd95,8'd255},
    {8'd55,8'd55,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd51,8'd200, 16'd40000,16'd22846,16'd8000, 8'd55,8'd0},
    {8'd45,8'd52,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd200, 16'd40000,16'd18750,16'd8000, 8'd45,8'd255},
    {8'd230,8'd228,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd201, 16'd40000,16'd20000,16'd11596, 8'd230,8'd0},
    {8'd10,8'd0,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd10, 16'd40000,16'd20000,16'd256, 8'd100,8'd255},
    {8'd119,8'd119,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd101,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd119,8'd0},
    {8'd120,8'd120,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd120, 16'd40000,16'd20000,16'd256, 8'd100,8'd255},
    {8'd110,8'd110,8'd51, 8'd100,8'd105,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd101,8'd105,8'd200, 16'd41596,16'd20000,16'd8000, 8'd110,8'd0},
    {8'd100,8'd100,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd100,8'd0},
    {8'd130,8'd130,8'd102, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd101,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd130,8'd0},
    {8'd100,8'd109,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd100,8'd0},
    {8'd100,8'd110,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd100,8'd50,8'd200, 16'd37500,16'd20000,16'd8000, 8'd100,8'd255},
    {8'd105,8'd105,8'd51, 8'd100,8'd50,8'd200, 16'd65535,16'd20000,16'd8000,
     8'd101,8'd50,8'd200, 16'd65535,16'd20000,16'd8000, 8'd105,8'd0},
    {8'd81,8'd81,8'd51, 8'd100,8'd50,8'd200, 16'd40000,16'd20000,16'd8000,
     8'd99,8'd50,8'd200, 16'd41596,16'd20000,16'd8000, 8'd81,8'd0}
  };

  // Requirement exercised by each vector
  localparam string TAG [NV] = '{
    "R5 bg step up", "R4 fg decay", "R3 second mode", "R4 fg second mode",
    "R5 third mode", "R7 no match", "R3 upper edge", "R7 one past edge",
    "R3 priority", "R5 equal mean", "R3 wide ratio", "R4 threshold equal",
    "R4 threshold above", "R5 saturation", "R3 lower edge"
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [7:0]  p, xp, r, m0, m1, m2, em0, em1, em2, ep, ef;
    logic [15:0] w0, w1, w2, ew0, ew1, ew2;
    {p, xp, r, m0, m1, m2, w0, w1, w2, em0, em1, em2, ew0, ew1, ew2, ep, ef} = VEC[i];
    @(negedge clk);
    pix_i = p; prev_i = xp; ratio_i = r;
    mean_i = {m2, m1, m0}; weight_i = {w2, w1, w0};
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({"R2 ", TAG[i]}, "valid after one edge", 64'(valid_o), 64'd0);
    @(negedge clk);
    check({"R2 ", TAG[i]}, "valid after two edges", 64'(valid_o), 64'd1);
    check({"R8 ", TAG[i]}, "means", 64'(mean_o), 64'({em2, em1, em0}));
    check({"R8 ", TAG[i]}, "weights", 64'(weight_o), 64'({ew2, ew1, ew0}));
    check({"R6 ", TAG[i]}, "processed", 64'(proc_o), 64'(ep));
    check({"R9 ", TAG[i]}, "foreground", 64'(fg_o), 64'(ef));
    @(negedge clk);
    check({"R2 ", TAG[i]}, "single pulse", 64'(valid_o), 64'd0);
  endtask

  task automatic check_reset_state(input string when);
    check({"R1 ", when}, "valid", 64'(valid_o), 64'd0);
    check({"R1 ", when}, "means", 64'(mean_o), 64'd0);
    check({"R1 ", when}, "weights", 64'(weight_o), 64'd0);
    check({"R1 ", when}, "processed", 64'(proc_o), 64'd0);
    check({"R1 ", when}, "foreground", 64'(fg_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state("after power-up");

    for (int i = 0; i < NV; i++) run_vec(i);

    // Reset in the middle of a pixel: no output pulse may survive it (R1, R2)
    @(negedge clk);
    pix_i = 8'd105; prev_i = 8'd105; ratio_i = 8'd51;
    mean_i = {8'd200, 8'd50, 8'd100};
    weight_i = {16'd8000, 16'd20000, 16'd40000};
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("mid-pixel");
    @(negedge clk);
    check("R2 flushed by reset", "valid", 64'(valid_o), 64'd0);

    // Back-to-back pixels keep order and spacing (R2)
    @(negedge clk);
    pix_i = 8'd105; prev_i = 8'd105; valid_i = 1'b1;
    @(negedge clk);
    pix_i = 8'd10; prev_i = 8'd0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R2 back-to-back first", "processed", 64'(proc_o), 64'd105);
    check("R2 back-to-back first", "valid", 64'(valid_o), 64'd1);
    @(negedge clk);
    check("R7 back-to-back second", "processed", 64'(proc_o), 64'd100);
    check("R9 back-to-back second", "foreground", 64'(fg_o), 64'd255);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule